// File: doc/BRIEF.md
# Lane-Partitioned Saturating Packed Adder

This block adds or subtracts two 64-bit operands that are each split into packed lanes. A single 64-bit adder does the work. A mode input decides where the carry chain is broken, so the same adder handles eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. No carry or borrow ever passes from one lane into the next.

Each lane can be treated as signed or unsigned. Each lane reports its own overflow. With saturation off, a lane that overflows keeps its modulo-wrapped value. With saturation on, the lane is clamped to the limit of its range in the direction of the overflow.

The result and the overflow mask are registered. Both appear one clock after the operands and controls are sampled.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_mode` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, and 2'b10 or 2'b11 give 32-bit lanes. No carry or borrow crosses a lane boundary.
- R2: When `sub_en`=0, each lane holds op_a + op_b modulo 2^lane-width, provided the lane does not saturate.
- R3: When `sub_en`=1, each lane holds op_a - op_b modulo 2^lane-width, provided the lane does not saturate.
- R4: `sum_q` and `ovf_mask` show the result of the operands and controls sampled at a rising clock edge. They change right after that edge.
- R5: While `rst_n` is low, `sum_q` and `ovf_mask` are zero. Assertion of `rst_n` takes effect at once, and its release is synchronized to the clock.
- R6: With `signed_en`=0, a lane overflows on add when a carry leaves its top bit. On subtract it overflows when op_a < op_b, which is a borrow.
- R7: With `signed_en`=1, a lane overflows when both addends have the same sign and the result sign differs from it. For subtract, the second addend is the negated op_b.
- R8: `ovf_mask` bit i covers bits 8i+7..8i of the result. Every bit of an overflowing lane is set, and every other bit is clear.
- R9: With `sat_en`=1 and `signed_en`=0, an overflowing lane becomes all ones on add and all zeros on subtract.
- R10: With `sat_en`=1 and `signed_en`=1, an overflowing lane becomes 0x7F..F when the true result is too large and 0x80..0 when it is too small.
- R11: `ovf_mask` is reported whether or not `sat_en` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| lane_mode | input | 2 | Lane width select |
| sub_en | input | 1 | 1 = subtract op_b from op_a |
| signed_en | input | 1 | 1 = lanes are two's complement |
| sat_en | input | 1 | 1 = clamp overflowing lanes |
| sum_q | output | 64 | Registered packed result |
| ovf_mask | output | 8 | Registered overflow flag per byte |

## Verification
Overflow detection and saturation can hit different lanes in the same cycle. This also happens in the cycle where a carry has to stop at a lane edge while it still travels through the byte boundaries inside a wider lane. Table vectors combine these cases on purpose, for example a positive and a negative signed overflow in neighbouring lanes beside lanes that do not overflow. The same operands are also run once with saturation off, which shows that the mask stays put while only the data changes. Each vector is judged on both outputs one clock after it is applied, against hand-computed lane values.

// File: rtl/psadd_pkg.sv
package psadd_pkg;
  typedef enum logic [1:0] {
    LANE8   = 2'b00,
    LANE16  = 2'b01,
    LANE32  = 2'b10,
    LANE32X = 2'b11
  } lane_mode_e;

  localparam int unsigned SEG_W = 8;
endpackage

// File: rtl/psadd_lane_map.sv
module psadd_lane_map
  import psadd_pkg::*;
#(
  parameter int unsigned NSEG = 8,
  localparam int unsigned IDX_W = $clog2(NSEG)
) (
  input  logic [1:0]       lane_mode,
  output logic [NSEG-1:0]  seg_first,
  output logic [IDX_W-1:0] span_mask
);
  always_comb begin
    unique case (lane_mode)
      LANE8:   span_mask = IDX_W'(0);
      LANE16:  span_mask = IDX_W'(1);
      default: span_mask = IDX_W'(3);
    endcase
  end

  generate
    for (genvar i = 0; i < NSEG; i++) begin : g_first
      assign seg_first[i] = ((IDX_W'(i) & span_mask) == '0);
    end
  endgenerate
endmodule

// File: rtl/psadd_carry_chain.sv
module psadd_carry_chain
  import psadd_pkg::*;
#(
  parameter int unsigned NSEG = 8,
  localparam int unsigned W = NSEG * SEG_W
) (
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic            sub_en,
  input  logic [NSEG-1:0] seg_first,
  output logic [W-1:0]    b_eff,
  output logic [W-1:0]    raw_sum,
  output logic [NSEG-1:0] seg_cout
);
  logic [NSEG-1:0] seg_cin;

  assign b_eff = op_b ^ {W{sub_en}};

  generate
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
      if (i == 0) begin : g_lsb
        assign seg_cin[i] = sub_en;
      end else begin : g_mid
        // a lane edge restarts the chain with the subtract carry-in
        assign seg_cin[i] = seg_first[i] ? sub_en : seg_cout[i-1];
      end
      assign {seg_cout[i], raw_sum[i*SEG_W +: SEG_W]} =
        {1'b0, op_a[i*SEG_W +: SEG_W]} + {1'b0, b_eff[i*SEG_W +: SEG_W]}
        + {{SEG_W{1'b0}}, seg_cin[i]};
    end
  endgenerate
endmodule

// File: rtl/psadd_saturate.sv
module psadd_saturate
  import psadd_pkg::*;
#(
  parameter int unsigned NSEG = 8,
  localparam int unsigned W = NSEG * SEG_W,
  localparam int unsigned IDX_W = $clog2(NSEG)
) (
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     b_eff,
  input  logic [W-1:0]     raw_sum,
  input  logic [NSEG-1:0]  seg_cout,
  input  logic [IDX_W-1:0] span_mask,
  input  logic             sub_en,
  input  logic             signed_en,
  input  logic             sat_en,
  output logic [W-1:0]     result,
  output logic [NSEG-1:0]  lane_ovf
);
  logic [NSEG-1:0] seg_ovf;

  generate
    for (genvar i = 0; i < NSEG; i++) begin : g_detect
      logic sa, sb, ss;
      assign sa = op_a[i*SEG_W + SEG_W - 1];
      assign sb = b_eff[i*SEG_W + SEG_W - 1];
      assign ss = raw_sum[i*SEG_W + SEG_W - 1];
      // only meaningful on the top segment of a lane
      assign seg_ovf[i] = signed_en ? ((sa == sb) && (ss != sa))
                                    : (seg_cout[i] ^ sub_en);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      logic [IDX_W-1:0] top;
      logic             neg, is_top;
      logic [SEG_W-1:0] clamp;
      top    = IDX_W'(i) | span_mask;
      is_top = (top == IDX_W'(i));
      neg    = op_a[int'(top)*SEG_W + SEG_W - 1];
      lane_ovf[i] = seg_ovf[top];
      if (signed_en) begin
        if (neg) clamp = is_top ? {1'b1, {(SEG_W-1){1'b0}}} : '0;
        else     clamp = is_top ? {1'b0, {(SEG_W-1){1'b1}}} : '1;
      end else begin
        clamp = sub_en ? '0 : '1;
      end
      result[i*SEG_W +: SEG_W] = (sat_en && lane_ovf[i]) ? clamp
                                 : raw_sum[i*SEG_W +: SEG_W];
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import psadd_pkg::*;
#(
  parameter int unsigned NSEG = 8,
  localparam int unsigned W = NSEG * SEG_W,
  localparam int unsigned IDX_W = $clog2(NSEG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [1:0]      lane_mode,
  input  logic            sub_en,
  input  logic            signed_en,
  input  logic            sat_en,
  output logic [W-1:0]    sum_q,
  output logic [NSEG-1:0] ovf_mask
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [NSEG-1:0]  seg_first;
  logic [IDX_W-1:0] span_mask;
  logic [W-1:0]     b_eff, raw_sum, sum_d;
  logic [NSEG-1:0]  seg_cout, ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  psadd_lane_map #(.NSEG(NSEG)) u_map (
    .lane_mode (lane_mode),
    .seg_first (seg_first),
    .span_mask (span_mask)
  );

  psadd_carry_chain #(.NSEG(NSEG)) u_chain (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_en    (sub_en),
    .seg_first (seg_first),
    .b_eff     (b_eff),
    .raw_sum   (raw_sum),
    .seg_cout  (seg_cout)
  );

  psadd_saturate #(.NSEG(NSEG)) u_sat (
    .op_a      (op_a),
    .b_eff     (b_eff),
    .raw_sum   (raw_sum),
    .seg_cout  (seg_cout),
    .span_mask (span_mask),
    .sub_en    (sub_en),
    .signed_en (signed_en),
    .sat_en    (sat_en),
    .result    (sum_d),
    .lane_ovf  (ovf_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sum_q    <= '0;
      ovf_mask <= '0;
    end else begin
      sum_q    <= sum_d;
      ovf_mask <= ovf_d;
    end
  end

  // R5: outputs cleared one edge after reset is seen low
  a_r5_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (sum_q == '0 && ovf_mask == '0));

  generate
    for (genvar i = 0; i < NSEG; i++) begin : g_chk
      // R8: mask uniform across the bytes of a lane
      a_r8_pair_uniform: assert property (@(posedge clk) disable iff (!rst_int_n)
        ($past(lane_mode) != LANE8) |-> (ovf_mask[i] == ovf_mask[i ^ 1]));
      a_r8_quad_uniform: assert property (@(posedge clk) disable iff (!rst_int_n)
        ($past(lane_mode) > LANE16) |-> (ovf_mask[i] == ovf_mask[i ^ 2]));
      // R9: unsigned clamp values
      a_r9_uadd_clamp: assert property (@(posedge clk) disable iff (!rst_int_n)
        ($past(sat_en && !signed_en && !sub_en) && ovf_mask[i])
        |-> (sum_q[i*SEG_W +: SEG_W] == '1));
      a_r9_usub_clamp: assert property (@(posedge clk) disable iff (!rst_int_n)
        ($past(sat_en && !signed_en && sub_en) && ovf_mask[i])
        |-> (sum_q[i*SEG_W +: SEG_W] == '0));
      // R10: signed clamp bytes are only limit patterns
      a_r10_sclamp_shape: assert property (@(posedge clk) disable iff (!rst_int_n)
        ($past(sat_en && signed_en) && ovf_mask[i])
        |-> (sum_q[i*SEG_W +: SEG_W - 1] == '0 || sum_q[i*SEG_W +: SEG_W - 1] == '1));
    end
  endgenerate
endmodule

// File: tb/simd_sat_adder_test.sv
module simd_sat_adder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic [1:0]  lane_mode;
  logic        sub_en, signed_en, sat_en;
  logic [63:0] sum_q;
  logic [7:0]  ovf_mask;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  simd_sat_adder uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .lane_mode(lane_mode), .sub_en(sub_en), .signed_en(signed_en),
    .sat_en(sat_en), .sum_q(sum_q), .ovf_mask(ovf_mask)
  );

  // {mode[1:0], sub, sgn, sat, a[63:0], b[63:0], res[63:0], ovf[7:0]}
  localparam int NV = 10;
  localparam logic [204:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 64'h01020304050607FF, 64'h0101010101010101, 64'h0203040506070800, 8'h01},
    {2'b00, 1'b0, 1'b0, 1'b1, 64'h01020304050607FF, 64'h0101010101010101, 64'h02030405060708FF, 8'h01},
    {2'b01, 1'b0, 1'b0, 1'b0, 64'h000000FFFFFF1234, 64'h0000000100010001, 64'h0000010000001235, 8'h0C},
    {2'b10, 1'b1, 1'b0, 1'b1, 64'h0000000500000010, 64'h0000000600000001, 64'h000000000000000F, 8'hF0},
    {2'b00, 1'b0, 1'b1, 1'b1, 64'h7F8010F000000000, 64'h01FF20F000000000, 64'h7F8030E000000000, 8'hC0},
    {2'b00, 1'b0, 1'b1, 1'b0, 64'h7F8010F000000000, 64'h01FF20F000000000, 64'h807F30E000000000, 8'hC0},
    {2'b01, 1'b1, 1'b1, 1'b1, 64'h000000057FFF8000, 64'h00010003FFFF0001, 64'hFFFF00027FFF8000, 8'h0F},
    {2'b11, 1'b0, 1'b0, 1'b0, 64'h00000000FFFFFFFF, 64'h0000000000000001, 64'h0000000000000000, 8'h0F},
    {2'b00, 1'b1, 1'b0, 1'b0, 64'h0000000000000000, 64'h0000000000000100, 64'h000000000000FF00, 8'h02},
    {2'b10, 1'b0, 1'b1, 1'b1, 64'h7FFFFFFF80000000, 64'h0000000180000000, 64'h7FFFFFFF80000000, 8'hFF}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1/R2/R6/R11";
      1: return "R9";
      2: return "R1/R2/R8";
      3: return "R3/R9";
      4: return "R7/R10";
      5: return "R11";
      6: return "R3/R8/R10";
      7: return "R1";
      8: return "R3/R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mask: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    op_a = 64'h0123456789ABCDEF;
    op_b = 64'hFFFFFFFFFFFFFFFF;
    lane_mode = 2'b00;
    sub_en = 1'b0;
    signed_en = 1'b0;
    sat_en = 1'b0;
    repeat (3) @(negedge clk);
    // R5: reset state
    check64("R5 reset result", sum_q, 64'h0);
    check8("R5 reset", ovf_mask, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: table vectors, each judged one edge later
    for (int i = 0; i < NV; i++) begin
      lane_mode = VEC[i][204:203];
      sub_en    = VEC[i][202];
      signed_en = VEC[i][201];
      sat_en    = VEC[i][200];
      op_a      = VEC[i][199:136];
      op_b      = VEC[i][135:72];
      @(negedge clk);
      check64(vec_tag(i), sum_q, VEC[i][71:8]);
      check8(vec_tag(i), ovf_mask, VEC[i][7:0]);
    end

    // R4: output holds the sample from the last edge only
    op_a = 64'h1111111111111111;
    op_b = 64'h2222222222222222;
    sub_en = 1'b0; signed_en = 1'b0; sat_en = 1'b0; lane_mode = 2'b00;
    @(posedge clk);
    #2;
    op_a = 64'h0;
    op_b = 64'h0;
    #1;
    check64("R4 capture", sum_q, 64'h3333333333333333);

    // R1: carry stops at each byte edge in 8-bit mode
    @(negedge clk);
    op_a = 64'hFFFFFFFFFFFFFFFF;
    op_b = 64'h0101010101010101;
    @(negedge clk);
    check64("R1 byte cut", sum_q, 64'h0);
    check8("R1/R6 byte cut", ovf_mask, 8'hFF);

    // R5: asynchronous assertion mid-run
    #2;
    rst_n = 1'b0;
    #1;
    check64("R5 async clear", sum_q, 64'h0);
    check8("R5 async clear", ovf_mask, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule